// File: doc/BRIEF.md
# Early cache set resolution detector

This block sits beside the decode and register-read stages of a load pipeline and decides, before the effective address exists, whether a load that uses base-plus-displacement addressing will touch the same cache set as its base register. When it can prove that, it sends a wake request for that set into the address-generation stage, so that a line held in a low-leakage retention state is awake by the time the real access arrives. The load then sees no extra cycle and no speculative consumers are squashed.

In the decode cycle the 16-bit displacement is sorted into three classes: zero, near (no bit at or above the line-offset field is set, value nonzero), and far (anything else, which includes every negative value). In the next cycle the base register value arrives from the register file. For a zero displacement the base is the address, so the set is always woken and the adder is switched off. For a near displacement, three small fixed tests on the 5-bit line offsets of base and displacement prove that the low-order add cannot carry into the index. Any load that passes none of them takes the normal path with no early wake.

All results are registered into the address-generation stage, two clock edges after the displacement was presented. The wake never names a set other than the one the full add produces.

Top module: `early_set_wake`

## Requirements
- R1: While rst_ni is low, ag_valid_o, agu_en_o, wake_o, cov_inc_o, wake_set_o and disp_class_o are all zero.
- R2: A load presented with dec_valid_i high in cycle t, whose base is driven on rr_base_i in cycle t+1, appears on ag_valid_o after the second rising edge (cycle t+2). disp_class_o then gives its class: 0 zero, 1 near, 2 far.
- R3: A valid load with displacement 0 raises wake_o and drops agu_en_o.
- R4: A valid load with a nonzero displacement raises agu_en_o.
- R5: A valid load with any of displacement bits 15..5 set, negative values included, never raises wake_o.
- R6: A near load wakes early when bit 4 of the base offset (base bits 4..0) and bit 4 of the displacement are both 0.
- R7: A near load wakes early when displacement bits 3..0 are all 0 and bit 4 of the base offset is 0.
- R8: A near load wakes early when base offset bits 4..3 are not 11 and displacement bits 4..3 are 00.
- R9: A near load that meets none of the tests in R6, R7 and R8 does not raise wake_o.
- R10: When wake_o is high, wake_set_o equals rr_base_i bits 13..5 of that load, and it also equals bits 13..5 of the base plus the sign-extended displacement. When wake_o is low, wake_set_o is 0.
- R11: cov_inc_o pulses for exactly the loads that raise wake_o.
- R12: A cycle with dec_valid_i low produces, two edges later, ag_valid_o, wake_o, agu_en_o and cov_inc_o all low, whatever the displacement and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dec_valid_i | input | 1 | A load is in the decode stage |
| dec_disp_i | input | 16 | Displacement field of the decoded load |
| rr_base_i | input | 32 | Base register value, one cycle after decode |
| ag_valid_o | output | 1 | Load is in the address-generation stage |
| agu_en_o | output | 1 | Address adder needed for this load |
| wake_o | output | 1 | Early set wake request |
| wake_set_o | output | 9 | Set index to wake |
| cov_inc_o | output | 1 | Coverage counter increment for an early wake |
| disp_class_o | output | 2 | Displacement class: 0 zero, 1 near, 2 far |

## Verification
The assertions take for granted that the base on rr_base_i in a given cycle belongs to the load decoded one cycle earlier. The set-match check rebuilds the effective address from that pairing. They also assume dec_valid_i is held low while reset is asserted, because the stage-valid property looks two edges back. The bench drives the load in cycle n and its base in cycle n+1, keeps dec_valid_i low during reset, and weights its random displacements toward zero, near and small negative values so that every carry test and every rejection path is hit often.

// File: rtl/esw_pkg.sv
package esw_pkg;
  typedef enum logic [1:0] {
    DISP_ZERO = 2'd0,
    DISP_NEAR = 2'd1,
    DISP_FAR  = 2'd2
  } disp_class_e;
endpackage

// File: rtl/esw_disp_classify.sv
module esw_disp_classify
  import esw_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int OFF_W  = 5
) (
  input  logic [DISP_W-1:0] disp_i,
  output disp_class_e       class_o,
  output logic [OFF_W-1:0]  off_o
);
  logic far, zero;

  assign far   = |disp_i[DISP_W-1:OFF_W];
  assign zero  = ~far & ~(|disp_i[OFF_W-1:0]);
  assign off_o = disp_i[OFF_W-1:0];

  always_comb begin
    if (far)       class_o = DISP_FAR;
    else if (zero) class_o = DISP_ZERO;
    else           class_o = DISP_NEAR;
  end
endmodule

// File: rtl/esw_carry_free.sv
module esw_carry_free #(
  parameter int         OFF_W    = 5,
  parameter logic [2:0] PAT_MASK = 3'b111
) (
  input  logic [OFF_W-1:0] base_off_i,
  input  logic [OFF_W-1:0] disp_off_i,
  output logic             safe_o
);
  localparam int NPAT = 3;
  localparam int TOP  = OFF_W - 1;

  logic [NPAT-1:0] hit;
  logic            unused_base_lo;

  assign unused_base_lo = ^base_off_i[OFF_W-3:0];

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    if (!PAT_MASK[p]) begin : g_off
      assign hit[p] = 1'b0;
    end else if (p == 0) begin : g_half
      // both below half a line
      assign hit[p] = ~base_off_i[TOP] & ~disp_off_i[TOP];
    end else if (p == 1) begin : g_align
      // displacement is exactly half a line, base in lower half
      assign hit[p] = (disp_off_i[TOP-1:0] == '0) & ~base_off_i[TOP];
    end else begin : g_quarter
      // base below three quarters, displacement below one quarter
      assign hit[p] = (base_off_i[TOP:TOP-1] != 2'b11) &
                      (disp_off_i[TOP:TOP-1] == 2'b00);
    end
  end

  assign safe_o = |hit;
endmodule

// File: rtl/early_set_wake.sv
module early_set_wake
  import esw_pkg::*;
#(
  parameter int         DISP_W   = 16,
  parameter int         ADDR_W   = 32,
  parameter int         OFF_W    = 5,
  parameter int         IDX_W    = 9,
  parameter logic [2:0] PAT_MASK = 3'b111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [DISP_W-1:0] dec_disp_i,
  input  logic [ADDR_W-1:0] rr_base_i,
  output logic              ag_valid_o,
  output logic              agu_en_o,
  output logic              wake_o,
  output logic [IDX_W-1:0]  wake_set_o,
  output logic              cov_inc_o,
  output logic [1:0]        disp_class_o
);
  localparam int SET_LO = OFF_W;
  localparam int SET_HI = OFF_W + IDX_W;

  disp_class_e      dec_class;
  logic [OFF_W-1:0] dec_off;

  logic             rr_valid_q;
  disp_class_e      rr_class_q;
  logic [OFF_W-1:0] rr_off_q;

  logic             carry_free;
  logic             early;
  logic             unused_base_hi;

  logic             ag_valid_q, ag_agu_q, ag_wake_q, ag_cov_q;
  logic [IDX_W-1:0] ag_set_q;
  disp_class_e      ag_class_q;

  assign unused_base_hi = ^rr_base_i[ADDR_W-1:SET_HI];

  esw_disp_classify #(.DISP_W(DISP_W), .OFF_W(OFF_W)) u_cls (
    .disp_i (dec_disp_i),
    .class_o(dec_class),
    .off_o  (dec_off)
  );

  // decode -> register read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_valid_q <= 1'b0;
      rr_class_q <= DISP_ZERO;
      rr_off_q   <= '0;
    end else begin
      rr_valid_q <= dec_valid_i;
      rr_class_q <= dec_class;
      rr_off_q   <= dec_off;
    end
  end

  esw_carry_free #(.OFF_W(OFF_W), .PAT_MASK(PAT_MASK)) u_cf (
    .base_off_i(rr_base_i[OFF_W-1:0]),
    .disp_off_i(rr_off_q),
    .safe_o    (carry_free)
  );

  always_comb begin
    early = 1'b0;
    if (rr_valid_q) begin
      unique case (rr_class_q)
        DISP_ZERO: early = 1'b1;
        DISP_NEAR: early = carry_free;
        default:   early = 1'b0;
      endcase
    end
  end

  // register read -> address generation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ag_valid_q <= 1'b0;
      ag_agu_q   <= 1'b0;
      ag_wake_q  <= 1'b0;
      ag_cov_q   <= 1'b0;
      ag_set_q   <= '0;
      ag_class_q <= DISP_ZERO;
    end else begin
      ag_valid_q <= rr_valid_q;
      ag_agu_q   <= rr_valid_q && (rr_class_q != DISP_ZERO);
      ag_wake_q  <= early;
      ag_cov_q   <= early;
      ag_set_q   <= early ? rr_base_i[SET_HI-1:SET_LO] : '0;
      ag_class_q <= rr_valid_q ? rr_class_q : DISP_ZERO;
    end
  end

  assign ag_valid_o   = ag_valid_q;
  assign agu_en_o     = ag_agu_q;
  assign wake_o       = ag_wake_q;
  assign cov_inc_o    = ag_cov_q;
  assign wake_set_o   = ag_set_q;
  assign disp_class_o = ag_class_q;
endmodule

// File: rtl/esw_checks.sv
module esw_checks #(
  parameter int DISP_W = 16,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dec_valid_i,
  input logic [DISP_W-1:0] dec_disp_i,
  input logic [ADDR_W-1:0] rr_base_i,
  input logic              ag_valid_o,
  input logic              agu_en_o,
  input logic              wake_o,
  input logic [IDX_W-1:0]  wake_set_o,
  input logic              cov_inc_o,
  input logic [1:0]        disp_class_o
);
  logic [DISP_W-1:0] disp_d1;
  logic [ADDR_W-1:0] eff_q, base_q;
  logic [ADDR_W-1:0] disp_sx;

  assign disp_sx = {{(ADDR_W-DISP_W){disp_d1[DISP_W-1]}}, disp_d1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_d1 <= '0;
      eff_q   <= '0;
      base_q  <= '0;
    end else begin
      disp_d1 <= dec_disp_i;
      eff_q   <= rr_base_i + disp_sx;
      base_q  <= rr_base_i;
    end
  end

  p_stage_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ag_valid_o == $past(dec_valid_i, 2));

  p_zero_skip_adder_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dec_valid_i, 2) && $past(dec_disp_i, 2) == '0) |-> (wake_o && !agu_en_o));

  p_far_no_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dec_valid_i, 2) && $past(dec_disp_i[DISP_W-1:OFF_W], 2) != '0)
      |-> (!wake_o && agu_en_o && disp_class_o == 2'd2));

  p_no_false_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (wake_set_o == eff_q[OFF_W+IDX_W-1:OFF_W] &&
                wake_set_o == base_q[OFF_W+IDX_W-1:OFF_W]));

  p_set_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_o |-> (wake_set_o == '0));

  p_cov_match_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cov_inc_o == wake_o);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ag_valid_o |-> (!wake_o && !agu_en_o && !cov_inc_o));
endmodule

bind early_set_wake esw_checks #(
  .DISP_W(DISP_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_valid_i (dec_valid_i),
  .dec_disp_i  (dec_disp_i),
  .rr_base_i   (rr_base_i),
  .ag_valid_o  (ag_valid_o),
  .agu_en_o    (agu_en_o),
  .wake_o      (wake_o),
  .wake_set_o  (wake_set_o),
  .cov_inc_o   (cov_inc_o),
  .disp_class_o(disp_class_o)
);

// File: tb/sim_early_set_wake.sv
`timescale 1ns/1ps
module sim_early_set_wake;
  localparam int NDIR  = 10;
  localparam int NLOAD = 4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dec_valid_i = 1'b0;
  logic [15:0] dec_disp_i = '0;
  logic [31:0] rr_base_i = '0;
  logic        ag_valid_o, agu_en_o, wake_o, cov_inc_o;
  logic [8:0]  wake_set_o;
  logic [1:0]  disp_class_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        hv [4];
  logic [15:0] hd [4];
  logic [31:0] hb [4];

  always #2 clk_i = ~clk_i;

  early_set_wake u0 (
    .clk_i, .rst_ni, .dec_valid_i, .dec_disp_i, .rr_base_i,
    .ag_valid_o, .agu_en_o, .wake_o, .wake_set_o, .cov_inc_o, .disp_class_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // class per R2: 0 zero, 1 near, 2 far
  function automatic logic [1:0] exp_class(input logic [15:0] d);
    if (d[15:5] != 0) return 2'd2;
    if (d == 0)       return 2'd0;
    return 2'd1;
  endfunction

  function automatic bit pat_a(input logic [4:0] b, input logic [4:0] d);
    return !b[4] && !d[4];                        // R6
  endfunction
  function automatic bit pat_b(input logic [4:0] b, input logic [4:0] d);
    return d[3:0] == 0 && !b[4];                  // R7
  endfunction
  function automatic bit pat_c(input logic [4:0] b, input logic [4:0] d);
    return b[4:3] != 2'b11 && d[4:3] == 2'b00;    // R8
  endfunction

  function automatic string wake_tag(input logic [15:0] d, input logic [31:0] b);
    if (d == 0)          return "R3";
    if (d[15:5] != 0)    return "R5";
    if (pat_a(b[4:0], d[4:0])) return "R6";
    if (pat_b(b[4:0], d[4:0])) return "R7";
    if (pat_c(b[4:0], d[4:0])) return "R8";
    return "R9";
  endfunction

  task automatic get_load(input int n, output logic v, output logic [15:0] d,
                          output logic [31:0] b);
    logic [31:0] r;
    r = $urandom;
    v = 1'b1;
    b = {r[31:5], 5'd0};
    case (n)
      0: begin d = 16'h0000; b = 32'h1234_5678; end        // R3
      1: begin v = 1'b0; d = 16'h0004; b |= 32'd3; end     // R12
      2: begin d = 16'd5;  b |= 32'd3;  end                // R6
      3: begin d = 16'd16; b |= 32'd15; end                // R7
      4: begin d = 16'd7;  b |= 32'd23; end                // R8
      5: begin d = 16'd8;  b |= 32'd24; end                // R9
      6: begin d = 16'd16; b |= 32'd16; end                // R9
      7: begin d = 16'hFFFF; b |= 32'd5; end               // R5
      8: begin d = 16'h0020; b |= 32'd0; end               // R5
      9: begin d = 16'h0000; b |= 32'd31; end              // R3
      default: begin
        b = $urandom;
        v = ($urandom % 8) != 0;
        case ($urandom % 8)
          0, 1:    d = 16'h0000;
          2, 3, 4: d = 16'($urandom % 32);
          5:       d = 16'(-(int'($urandom % 64) + 1));
          default: d = 16'($urandom);
        endcase
      end
    endcase
  endtask

  task automatic check_load(input logic v, input logic [15:0] d, input logic [31:0] b);
    bit          ew;
    logic [31:0] sum;
    ew  = v && (d == 0 || (d[15:5] == 0 &&
          (pat_a(b[4:0], d[4:0]) || pat_b(b[4:0], d[4:0]) || pat_c(b[4:0], d[4:0]))));
    sum = b + {{16{d[15]}}, d};
    chk(ag_valid_o == v, "R2 ag_valid", 32'(ag_valid_o), 32'(v));
    chk(disp_class_o == (v ? exp_class(d) : 2'd0), "R2 class",
        32'(disp_class_o), 32'(v ? exp_class(d) : 2'd0));
    chk(agu_en_o == (v && d != 0), v ? (d == 0 ? "R3 agu" : "R4 agu") : "R12 agu",
        32'(agu_en_o), 32'(v && d != 0));
    chk(wake_o == ew, v ? wake_tag(d, b) : "R12 wake", 32'(wake_o), 32'(ew));
    chk(cov_inc_o == ew, "R11 cov", 32'(cov_inc_o), 32'(ew));
    chk(wake_set_o == (ew ? b[13:5] : 9'd0), "R10 set",
        32'(wake_set_o), 32'(ew ? b[13:5] : 9'd0));
    if (wake_o)
      chk(wake_set_o == sum[13:5], "R10 sum index", 32'(wake_set_o), 32'(sum[13:5]));
  endtask

  initial begin
    void'($urandom(32'd20031));
    repeat (3) @(negedge clk_i);
    chk(!ag_valid_o && !agu_en_o && !wake_o && !cov_inc_o, "R1 flags",
        {ag_valid_o, agu_en_o, wake_o, cov_inc_o}, 32'd0);
    chk(wake_set_o == 0 && disp_class_o == 0, "R1 set/class",
        {wake_set_o, disp_class_o}, 32'd0);
    rst_ni = 1'b1;
    for (int n = 0; n < NLOAD + 2; n++) begin
      @(negedge clk_i);
      if (n >= 2) check_load(hv[(n-2)%4], hd[(n-2)%4], hb[(n-2)%4]);
      if (n < NLOAD) begin
        logic v; logic [15:0] d; logic [31:0] b;
        get_load(n, v, d, b);
        hv[n%4] = v; hd[n%4] = d; hb[n%4] = b;
        dec_valid_i = v;
        dec_disp_i  = d;
      end else begin
        dec_valid_i = 1'b0;
        dec_disp_i  = '0;
      end
      rr_base_i = (n >= 1 && n <= NLOAD) ? hb[(n-1)%4] : 32'd0;
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule